// File: doc/BRIEF.md
# Masked Priority Interrupt Controller

This block gathers fifteen internal interrupt sources into one request line toward a processor core. Each source sets a sticky pending flag, and a separate enable register decides whether a pending flag may drive the request. The request goes high whenever at least one source is both pending and enabled. A masked source still records its events, so software can inspect or re-enable it later without losing anything.

During an interrupt acknowledge, the block returns a 5-bit vector. This vector is the index of the highest-priority source that is pending and enabled, and the highest index wins. If the enable register is written in the same cycle as the acknowledge, the new enable value decides the vector. In that case the acknowledge falls back to the next enabled pending source. If no such source is left, it returns the error vector 0. Software reads both registers, writes the enable register, and clears pending flags by writing ones.

Top module: `irq_mask_prio_ctrl`

## Requirements
- R1: After reset, the enable register reads 0x0000, the pending register reads 0x0000, `irq_req` is 0, and `iack_vec` is 0.
- R2: An event on source bit k (15..1) sets pending bit k at the next clock edge whatever the enable bit is. An event alone never clears a pending bit.
- R3: `irq_req` is 1 exactly when some bit in 15..1 is set in both the pending and the enable register.
- R4: Clearing the enable bit of a pending, requesting source drops `irq_req` after that write. The pending bit stays set.
- R5: Setting the enable bit again while the pending bit is still set raises `irq_req` again. The next acknowledge returns that source's index.
- R6: Writing 1 to pending bit k clears it, and writing 0 leaves it unchanged. If an event on k and a clear of k arrive in the same cycle, bit k ends up set.
- R7: While `iack` is 1, `iack_vec` equals the highest index k in 15..1 whose pending and enable bits are both set. It is 0 when there is no such k.
- R8: If `mask_wr_en` and `iack` are both 1 in the same cycle, `iack_vec` is computed with `mask_wr_data` in place of the enable register. The result is the next enabled pending source, or 0 if none is left.
- R9: Bit 0 of the enable register and bit 0 of the pending register always read 0. Writes and events on bit 0 have no effect on `irq_req` or on the vector.
- R10: While `iack` is 0, `iack_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 16 | One-cycle event strobes per source; bit 0 unused |
| mask_wr_en | input | 1 | Write strobe for the enable register |
| mask_wr_data | input | 16 | New enable value (1 = enabled) |
| pend_clr_en | input | 1 | Clear strobe for the pending register |
| pend_clr_data | input | 16 | Ones mark pending bits to clear |
| iack | input | 1 | Acknowledge strobe from the core |
| mask_rd | output | 16 | Current enable register |
| pend_rd | output | 16 | Current pending register |
| irq_req | output | 1 | Interrupt request toward the core |
| iack_vec | output | 5 | Vector returned during acknowledge |

## Verification
The vector table tries single sources, several simultaneous sources with the top one enabled or disabled, sparse interleaved masks, an all-disabled mask, and a lone bit-0 event. Together these separate a correct priority order from a lowest-first or unmasked choice, and show whether bit 0 leaks into the request. Directed sequences then disable and re-enable a pending source to show that the request and the pending flag are decoupled. They collide an event with a clear on one bit, and they race an enable write against an acknowledge. The race is run once with a lower source left to fall back on and once with none, which tells the fallback apart from the error vector.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int SRC_W = 16;
    localparam int VEC_W = 5;

    typedef logic [SRC_W-1:0] src_vec_t;
    typedef logic [VEC_W-1:0] irq_vec_t;

    typedef struct packed {
        logic     wr;
        src_vec_t data;
    } reg_wr_t;

    typedef struct packed {
        logic     valid;
        irq_vec_t index;
    } sel_t;

    // Highest set index in 15..1; bit 0 never selected.
    function automatic sel_t pick_highest(input src_vec_t cand);
        sel_t r;
        r.valid = 1'b0;
        r.index = '0;
        for (int i = 1; i < SRC_W; i++) begin
            if (cand[i]) begin
                r.valid = 1'b1;
                r.index = irq_vec_t'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt_i,
    input  reg_wr_t  clr_i,
    output src_vec_t pend_o
);

    src_vec_t pend_q;
    src_vec_t clr_mask;

    assign clr_mask = clr_i.wr ? clr_i.data : '0;

    assign pend_q[0] = 1'b0;

    for (genvar g = 1; g < SRC_W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
            end else if (evt_i[g]) begin
                pend_q[g] <= 1'b1;
            end else if (clr_mask[g]) begin
                pend_q[g] <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;

    // R2 R6
    evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_o & ($past(evt_i) & ~src_vec_t'(1))) == ($past(evt_i) & ~src_vec_t'(1))));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_o & ~$past(evt_i | clr_mask)) == ($past(pend_o) & ~$past(evt_i | clr_mask))));

    // R6
    clr_only_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_o & ($past(clr_mask) & ~$past(evt_i))) == '0));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_wr_t  wr_i,
    output src_vec_t mask_o
);

    src_vec_t mask_q;

    assign mask_q[0] = 1'b0;

    for (genvar g = 1; g < SRC_W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[g] <= 1'b0;
            end else if (wr_i.wr) begin
                mask_q[g] <= wr_i.data[g];
            end
        end
    end

    assign mask_o = mask_q;

    // R9
    bit0_zero_chk: assert property (@(posedge clk) mask_o[0] == 1'b0);

    // R4 R5
    mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i.wr |=> (mask_o == ($past(wr_i.data) & ~src_vec_t'(1))));

    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i.wr |=> $stable(mask_o));

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t cand_i,
    output sel_t     sel_o
);

    assign sel_o = pick_highest(cand_i);

    // R7
    prio_top_chk: assert property (@(posedge clk) disable iff (rst)
        sel_o.valid |-> ((cand_i >> sel_o.index) == src_vec_t'(1)));

    // R7
    prio_none_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_o.valid |-> ((cand_i & ~src_vec_t'(1)) == '0));

endmodule

// File: rtl/irq_mask_prio_ctrl.sv
module irq_mask_prio_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_W-1:0]     src_evt,
    input  logic                 mask_wr_en,
    input  logic [SRC_W-1:0]     mask_wr_data,
    input  logic                 pend_clr_en,
    input  logic [SRC_W-1:0]     pend_clr_data,
    input  logic                 iack,
    output logic [SRC_W-1:0]     mask_rd,
    output logic [SRC_W-1:0]     pend_rd,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     iack_vec
);

    reg_wr_t  mask_wr;
    reg_wr_t  pend_clr;
    src_vec_t pend;
    src_vec_t mask;
    src_vec_t ack_mask;
    sel_t     ack_sel;

    assign mask_wr.wr    = mask_wr_en;
    assign mask_wr.data  = mask_wr_data;
    assign pend_clr.wr   = pend_clr_en;
    assign pend_clr.data = pend_clr_data;

    irq_pend_reg i_pend (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (src_evt),
        .clr_i  (pend_clr),
        .pend_o (pend)
    );

    irq_mask_reg i_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (mask_wr),
        .mask_o (mask)
    );

    // An enable write racing the acknowledge decides the vector.
    assign ack_mask = mask_wr_en ? (mask_wr_data & ~src_vec_t'(1)) : mask;

    irq_prio_sel i_sel (
        .clk    (clk),
        .rst    (rst),
        .cand_i (pend & ack_mask),
        .sel_o  (ack_sel)
    );

    assign irq_req  = |(pend[SRC_W-1:1] & mask[SRC_W-1:1]);
    assign iack_vec = (iack && ack_sel.valid) ? ack_sel.index : '0;
    assign mask_rd  = mask;
    assign pend_rd  = pend;

    // R8
    race_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (iack && mask_wr_en && iack_vec != '0) |-> (mask_wr_data[iack_vec] && pend_rd[iack_vec]));

    // R10
    idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
        !iack |-> (iack_vec == '0));

    // R3
    req_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (iack && !mask_wr_en && !irq_req) |-> (iack_vec == '0));

    // R1
    reset_chk: assert property (@(posedge clk)
        rst |=> (mask_rd == '0 && pend_rd == '0 && !irq_req));

endmodule

// File: tb/test_irq_mask_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_mask_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_evt = '0;
    logic        mask_wr_en = 1'b0;
    logic [15:0] mask_wr_data = '0;
    logic        pend_clr_en = 1'b0;
    logic [15:0] pend_clr_data = '0;
    logic        iack = 1'b0;
    logic [15:0] mask_rd;
    logic [15:0] pend_rd;
    logic        irq_req;
    logic [4:0]  iack_vec;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    irq_mask_prio_ctrl i_irq_mask_prio_ctrl (
        .clk(clk), .rst(rst), .src_evt(src_evt),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .pend_clr_en(pend_clr_en), .pend_clr_data(pend_clr_data),
        .iack(iack), .mask_rd(mask_rd), .pend_rd(pend_rd),
        .irq_req(irq_req), .iack_vec(iack_vec)
    );

    // {mask, events, expected request, expected vector}
    localparam int NV = 8;
    localparam logic [37:0] VECS [NV] = '{
        {16'hFFFE, 16'h0002, 1'b1, 5'd1},
        {16'hFFFE, 16'h8002, 1'b1, 5'd15},
        {16'h7FFE, 16'h8002, 1'b1, 5'd1},
        {16'h0000, 16'hFFFE, 1'b0, 5'd0},
        {16'h0F00, 16'h3300, 1'b1, 5'd9},
        {16'h0010, 16'h0030, 1'b1, 5'd4},
        {16'hFFFF, 16'h0001, 1'b0, 5'd0},
        {16'hAAAA, 16'h5554, 1'b0, 5'd0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_mask(input logic [15:0] v);
        mask_wr_en = 1'b1; mask_wr_data = v;
        tick();
        mask_wr_en = 1'b0;
    endtask

    task automatic clr_pend(input logic [15:0] v);
        pend_clr_en = 1'b1; pend_clr_data = v;
        tick();
        pend_clr_en = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] v);
        src_evt = v;
        tick();
        src_evt = '0;
    endtask

    task automatic ack_vec(input string req, input logic [4:0] exp);
        iack = 1'b1;
        #1;
        chk(req, 32'(iack_vec), 32'(exp));
        tick();
        iack = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk("R1 mask", 32'(mask_rd), 0);
        chk("R1 pend", 32'(pend_rd), 0);
        chk("R1 irq", 32'(irq_req), 0);
        chk("R1 vec", 32'(iack_vec), 0);

        for (int n = 0; n < NV; n++) begin
            wr_mask(VECS[n][37:22]);
            clr_pend(16'hFFFF);
            pulse(VECS[n][21:6]);
            chk("R9 mask rd", 32'(mask_rd), 32'(VECS[n][37:22] & 16'hFFFE));
            chk("R2 R9 pend", 32'(pend_rd), 32'(VECS[n][21:6] & 16'hFFFE));
            chk("R3 irq", 32'(irq_req), 32'(VECS[n][5]));
            chk("R10 idle vec", 32'(iack_vec), 0);
            ack_vec("R7 vec", VECS[n][4:0]);
        end

        // R4 / R5 disable then re-enable a pending source
        wr_mask(16'h0000);
        clr_pend(16'hFFFF);
        wr_mask(16'h0400);
        pulse(16'h0400);
        chk("R3 irq on", 32'(irq_req), 1);
        wr_mask(16'h0000);
        chk("R4 irq off", 32'(irq_req), 0);
        chk("R4 pend kept", 32'(pend_rd), 32'h0400);
        pulse(16'h0000);
        chk("R2 pend sticky", 32'(pend_rd), 32'h0400);
        wr_mask(16'h0400);
        chk("R5 irq back", 32'(irq_req), 1);
        ack_vec("R5 vec", 5'd10);

        // R6 write-one-to-clear and collision
        pulse(16'h0006);
        clr_pend(16'h0004);
        chk("R6 clear one", 32'(pend_rd), 32'h0402);
        src_evt = 16'h0002; pend_clr_en = 1'b1; pend_clr_data = 16'h0002;
        tick();
        src_evt = '0; pend_clr_en = 1'b0;
        chk("R6 event wins", 32'(pend_rd), 32'h0402);
        clr_pend(16'h0000);
        chk("R6 zero no effect", 32'(pend_rd), 32'h0402);

        // R8 race with fallback: pending 10 and 1, enable 10 and 1, disable 10 at ack
        wr_mask(16'h0402);
        iack = 1'b1; mask_wr_en = 1'b1; mask_wr_data = 16'h0002;
        #1;
        chk("R8 fallback", 32'(iack_vec), 1);
        tick();
        iack = 1'b0; mask_wr_en = 1'b0;
        chk("R8 mask applied", 32'(mask_rd), 32'h0002);

        // R8 race with nothing left
        clr_pend(16'h0002);
        wr_mask(16'h0400);
        iack = 1'b1; mask_wr_en = 1'b1; mask_wr_data = 16'h0001;
        #1;
        chk("R8 error vec", 32'(iack_vec), 0);
        tick();
        iack = 1'b0; mask_wr_en = 1'b0;
        chk("R9 bit0 mask", 32'(mask_rd), 0);
        chk("R4 irq none", 32'(irq_req), 0);

        // R1 reset again clears everything
        wr_mask(16'hFFFF);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 re-reset mask", 32'(mask_rd), 0);
        chk("R1 re-reset pend", 32'(pend_rd), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule